// File: doc/BRIEF.md
# Interrupt Vector Dispatch Unit

This unit sits beside a processor core and turns the events that redirect control flow into one dispatch per cycle. Three sources feed it: synchronous exceptions raised by the core (vectors 0 to 31), software interrupt requests that carry a vector and the ring of the code that issued them, and sixteen level-sensitive device lines mapped onto vectors 32 to 47. A 256-entry descriptor table, loaded through a write-only configuration port, gives each vector a handler address, the least privileged ring allowed to raise it from software, a present bit and a gate kind (interrupt or trap).

For each request the unit looks up the descriptor, decides whether a protection fault must replace it, and issues a registered one-cycle dispatch that carries the vector, the handler address, the source and a substitution flag. The core keeps an exception or software request raised until a dispatch names that source. Entry through an interrupt gate clears the enable flag, while a trap gate leaves it alone. Every accepted dispatch pushes the prior enable value and any line taken into service onto an internal stack 8 deep, and the return input pops that stack.

Top module: `vec_dispatch`

## Requirements
- R1: After reset no dispatch is issued, the enable flag is clear, no line is in service, the overflow flag is clear, the fault address reads zero and every descriptor counts as not present.
- R2: A configuration write to vector v takes effect from the next cycle, and a later dispatch that resolves to v presents the written handler address.
- R3: A software request from ring r to a present vector whose descriptor ring is d dispatches that vector when r <= d. When r > d it dispatches vector 13 with the substitution flag set.
- R4: Any request that resolves to a descriptor with the present bit clear dispatches vector 13 with the address held in entry 13 and the substitution flag set.
- R5: Entry through an interrupt gate clears the enable flag, and the return that pops that entry puts back the value the flag had before entry. Entry and return through a trap gate leave the flag unchanged.
- R6: While the enable flag is clear no device line is dispatched. Exceptions and software requests still dispatch.
- R7: A line that is in service is not dispatched again until the return that pops it. A different ready line may be dispatched on top of it.
- R8: When several sources are ready in one cycle, an exception wins over a software request, which wins over a device line. Among device lines, the lowest index wins.
- R9: An exception on vector 14 that is not substituted loads the fault address input into the fault address output. That output holds until the next such dispatch.
- R10: At most 8 dispatches can be outstanding. A request made while 8 are outstanding is not dispatched and sets an overflow flag that stays set until reset.
- R11: A request accepted on a clock edge shows disp_valid high for the cycle after that edge. disp_src then reads 1 for an exception, 2 for a software request and 3 for a device line.
- R12: A pulse on ie_clr clears the enable flag and a pulse on ie_set sets it, each on the next edge.
- R13: In a cycle with ret high no dispatch is issued. A return with nothing outstanding changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_vec | input | 8 | Descriptor index to write |
| cfg_addr | input | AW | Handler address to store |
| cfg_ring | input | RW | Least privileged ring allowed for software entry |
| cfg_present | input | 1 | Present bit to store |
| cfg_trap | input | 1 | 1 for a trap gate, 0 for an interrupt gate |
| exc_req | input | 1 | Exception request, held until dispatched |
| exc_vec | input | 5 | Exception vector |
| exc_addr | input | AW | Faulting address that goes with the exception |
| sw_req | input | 1 | Software interrupt request, held until dispatched |
| sw_vec | input | 8 | Software vector |
| sw_ring | input | RW | Ring of the requesting code |
| irq_lines | input | NLINES | Level device request lines |
| ie_clr | input | 1 | Clear the enable flag |
| ie_set | input | 1 | Set the enable flag |
| ret | input | 1 | Return from the most recent handler |
| disp_valid | output | 1 | One-cycle dispatch pulse |
| disp_src | output | 2 | Source of the dispatch |
| disp_vec | output | 8 | Dispatched vector |
| disp_addr | output | AW | Handler address |
| disp_gp | output | 1 | Protection fault substituted |
| ie | output | 1 | Enable flag |
| in_service | output | NLINES | Lines now in service |
| fault_addr | output | AW | Latched faulting address |
| nest_ovf | output | 1 | Sticky overflow of the nesting stack |

## Verification
The hardest state to reach is a full nesting stack, where a ninth request arrives while eight handlers are outstanding. The stimulus gets there by issuing trap-gate software requests back to back with no return between them, so the enable flag never blocks progress. It then returns nine times to drain the stack and to try a return on an empty stack. A second hard case is a cycle in which all three sources are ready together. Here the stimulus holds each request up and drops it only after the reference model has seen that source dispatched, so the order is taken from the priority rule and not from the timing of the stimulus.

// File: rtl/vd_pkg.sv
package vd_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXC  = 2'd1,
    SRC_SW   = 2'd2,
    SRC_IRQ  = 2'd3
  } vd_src_e;

  localparam logic [7:0] VD_VEC_GP = 8'd13;
  localparam logic [7:0] VD_VEC_PF = 8'd14;
endpackage

// File: rtl/vd_desc_table.sv
module vd_desc_table #(
  parameter int NVEC = 256,
  parameter int AW   = 32,
  parameter int RW   = 2,
  localparam int IW  = $clog2(NVEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [AW-1:0] waddr,
  input  logic [RW-1:0] wring,
  input  logic          wpres,
  input  logic          wtrap,
  input  logic [IW-1:0] a_idx,
  output logic [AW-1:0] a_addr,
  output logic [RW-1:0] a_ring,
  output logic          a_pres,
  output logic          a_trap,
  input  logic [IW-1:0] b_idx,
  output logic [AW-1:0] b_addr,
  output logic          b_trap
);
  logic [AW-1:0]   addr_mem [NVEC];
  logic [RW-1:0]   ring_mem [NVEC];
  logic [NVEC-1:0] trap_mem;
  logic [NVEC-1:0] pres_q;
  logic [NVEC-1:0] pres_d;

  // payload storage carries no reset, only a write enable
  always_ff @(posedge clk) begin
    if (we) begin
      addr_mem[widx] <= waddr;
      ring_mem[widx] <= wring;
      trap_mem[widx] <= wtrap;
    end
  end

  always_comb begin
    pres_d = pres_q;
    if (we) pres_d[widx] = wpres;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pres_q <= '0;
    else        pres_q <= pres_d;
  end

  assign a_addr = addr_mem[a_idx];
  assign a_ring = ring_mem[a_idx];
  assign a_pres = pres_q[a_idx];
  assign a_trap = trap_mem[a_idx];
  assign b_addr = addr_mem[b_idx];
  assign b_trap = trap_mem[b_idx];
endmodule

// File: rtl/vd_line_pick.sv
module vd_line_pick #(
  parameter int N  = 16,
  localparam int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [LW-1:0] idx
);
  logic [N-1:0] grant;

  for (genvar gi = 0; gi < N; gi++) begin : g_line
    localparam logic [N-1:0] LOWER = (N'(1) << gi) - N'(1);
    assign grant[gi] = req[gi] && ((req & LOWER) == '0);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = idx | LW'(i);
    end
  end

  assign any = |req;

  // R8: the lowest ready line is the only one granted
  p_single_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any == (grant != '0)));
endmodule

// File: rtl/vd_nest_stack.sv
module vd_nest_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [PW-1:0] wr_idx;
  logic [PW-1:0] rd_idx;

  assign wr_idx = cnt_q[PW-1:0];
  assign rd_idx = PW'(cnt_q - CW'(1));
  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == CW'(DEPTH));
  assign top    = mem[rd_idx];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (wr_idx == PW'(gi))) mem[gi] <= din;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (push)     cnt_d = cnt_q + CW'(1);
    else if (pop) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R10: the owner never pushes into a full stack
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R13: the owner never pops an empty stack
  p_no_underflow_r13: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (!empty && !push));
endmodule

// File: rtl/vec_dispatch.sv
module vec_dispatch
  import vd_pkg::*;
#(
  parameter int AW       = 32,
  parameter int RW       = 2,
  parameter int NLINES   = 16,
  parameter int IRQ_BASE = 32,
  parameter int DEPTH    = 8,
  parameter int NEXC     = 32,
  localparam int VW      = 8,
  localparam int EW      = $clog2(NEXC),
  localparam int LW      = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [VW-1:0]     cfg_vec,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [RW-1:0]     cfg_ring,
  input  logic              cfg_present,
  input  logic              cfg_trap,
  input  logic              exc_req,
  input  logic [EW-1:0]     exc_vec,
  input  logic [AW-1:0]     exc_addr,
  input  logic              sw_req,
  input  logic [VW-1:0]     sw_vec,
  input  logic [RW-1:0]     sw_ring,
  input  logic [NLINES-1:0] irq_lines,
  input  logic              ie_clr,
  input  logic              ie_set,
  input  logic              ret,
  output logic              disp_valid,
  output logic [1:0]        disp_src,
  output logic [VW-1:0]     disp_vec,
  output logic [AW-1:0]     disp_addr,
  output logic              disp_gp,
  output logic              ie,
  output logic [NLINES-1:0] in_service,
  output logic [AW-1:0]     fault_addr,
  output logic              nest_ovf
);
  localparam int SW_ = 3 + LW;  // stack entry: saved ie, int gate, irq, line

  // state
  logic              ie_q, ie_d;
  logic [NLINES-1:0] isv_q, isv_d;
  logic              ovf_q, ovf_d;
  logic [AW-1:0]     fa_q, fa_d;
  logic              val_q;
  vd_src_e           src_q;
  logic [VW-1:0]     vec_q;
  logic [AW-1:0]     adr_q;
  logic              gp_q;

  // decision
  logic              irq_any;
  logic [LW-1:0]     irq_idx;
  vd_src_e           src_sel;
  logic [VW-1:0]     raw_vec, fin_vec;
  logic [AW-1:0]     a_addr, b_addr, fin_addr;
  logic [RW-1:0]     a_ring;
  logic              a_pres, a_trap, b_trap, fin_trap;
  logic              want, accept, gp, pop;
  logic              stk_empty, stk_full;
  logic [SW_-1:0]    push_ent, top_ent;

  vd_line_pick #(.N(NLINES)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(irq_lines & ~isv_q),
    .any(irq_any), .idx(irq_idx)
  );

  vd_desc_table #(.NVEC(1 << VW), .AW(AW), .RW(RW)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .we(cfg_we), .widx(cfg_vec), .waddr(cfg_addr), .wring(cfg_ring),
    .wpres(cfg_present), .wtrap(cfg_trap),
    .a_idx(raw_vec), .a_addr(a_addr), .a_ring(a_ring), .a_pres(a_pres), .a_trap(a_trap),
    .b_idx(VD_VEC_GP), .b_addr(b_addr), .b_trap(b_trap)
  );

  vd_nest_stack #(.DEPTH(DEPTH), .W(SW_)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(accept), .pop(pop),
    .din(push_ent), .top(top_ent), .empty(stk_empty), .full(stk_full)
  );

  // source selection: return blocks, then exception, software, device
  always_comb begin
    if (ret)                    src_sel = SRC_NONE;
    else if (exc_req)           src_sel = SRC_EXC;
    else if (sw_req)            src_sel = SRC_SW;
    else if (ie_q && irq_any)   src_sel = SRC_IRQ;
    else                        src_sel = SRC_NONE;
  end

  always_comb begin
    unique case (src_sel)
      SRC_EXC: raw_vec = VW'(exc_vec);
      SRC_SW:  raw_vec = sw_vec;
      SRC_IRQ: raw_vec = VW'(IRQ_BASE) + VW'(irq_idx);
      default: raw_vec = '0;
    endcase
  end

  assign want     = (src_sel != SRC_NONE);
  assign gp       = want && (!a_pres || ((src_sel == SRC_SW) && (sw_ring > a_ring)));
  assign fin_vec  = gp ? VD_VEC_GP : raw_vec;
  assign fin_addr = gp ? b_addr : a_addr;
  assign fin_trap = gp ? b_trap : a_trap;
  assign accept   = want && !stk_full;
  assign pop      = ret && !stk_empty;
  assign push_ent = {ie_q, !fin_trap, (src_sel == SRC_IRQ), irq_idx};

  // next state
  always_comb begin
    ie_d = ie_q;
    if (ie_clr) ie_d = 1'b0;
    if (ie_set) ie_d = 1'b1;
    if (pop && top_ent[LW+1]) ie_d = top_ent[LW+2];
    if (accept && !fin_trap)  ie_d = 1'b0;

    isv_d = isv_q;
    if (pop && top_ent[LW])            isv_d[top_ent[LW-1:0]] = 1'b0;
    if (accept && (src_sel == SRC_IRQ)) isv_d[irq_idx]         = 1'b1;

    ovf_d = ovf_q | (want && stk_full);

    fa_d = fa_q;
    if (accept && (src_sel == SRC_EXC) && !gp && (raw_vec == VD_VEC_PF)) fa_d = exc_addr;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      isv_q <= '0;
      ovf_q <= 1'b0;
      fa_q  <= '0;
      val_q <= 1'b0;
      src_q <= SRC_NONE;
      vec_q <= '0;
      adr_q <= '0;
      gp_q  <= 1'b0;
    end else begin
      ie_q  <= ie_d;
      isv_q <= isv_d;
      ovf_q <= ovf_d;
      fa_q  <= fa_d;
      val_q <= accept;
      if (accept) begin
        src_q <= src_sel;
        vec_q <= fin_vec;
        adr_q <= fin_addr;
        gp_q  <= gp;
      end
    end
  end

  assign disp_valid = val_q;
  assign disp_src   = src_q;
  assign disp_vec   = vec_q;
  assign disp_addr  = adr_q;
  assign disp_gp    = gp_q;
  assign ie         = ie_q;
  assign in_service = isv_q;
  assign fault_addr = fa_q;
  assign nest_ovf   = ovf_q;

  // R13: a return cycle never produces a dispatch
  p_ret_blocks_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ret |=> !disp_valid);
  // R6: a device dispatch needs the flag set on the accepting edge
  p_irq_needs_ie_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && (disp_src == SRC_IRQ)) |-> $past(ie_q));
  // R7: a device dispatch leaves its line marked in service
  p_irq_marked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && (disp_src == SRC_IRQ) && !disp_gp) |->
      isv_q[LW'(disp_vec - VW'(IRQ_BASE))]);
  // R4: a substitution always names the protection vector
  p_gp_vector_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_gp) |-> (disp_vec == VD_VEC_GP));
  // R10: overflow stays set
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
endmodule

// File: tb/sim_vec_dispatch.sv
module sim_vec_dispatch;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          cfg_we = 0, cfg_present = 0, cfg_trap = 0;
  logic [7:0]    cfg_vec = 0;
  logic [AW-1:0] cfg_addr = 0;
  logic [1:0]    cfg_ring = 0;
  logic          exc_req = 0, sw_req = 0, ie_clr = 0, ie_set = 0, ret = 0;
  logic [4:0]    exc_vec = 0;
  logic [AW-1:0] exc_addr = 0;
  logic [7:0]    sw_vec = 0;
  logic [1:0]    sw_ring = 0;
  logic [15:0]   irq_lines = 0;

  logic          disp_valid, disp_gp, ie, nest_ovf;
  logic [1:0]    disp_src;
  logic [7:0]    disp_vec;
  logic [AW-1:0] disp_addr, fault_addr;
  logic [15:0]   in_service;

  vec_dispatch u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_vec(cfg_vec), .cfg_addr(cfg_addr), .cfg_ring(cfg_ring),
    .cfg_present(cfg_present), .cfg_trap(cfg_trap),
    .exc_req(exc_req), .exc_vec(exc_vec), .exc_addr(exc_addr),
    .sw_req(sw_req), .sw_vec(sw_vec), .sw_ring(sw_ring),
    .irq_lines(irq_lines), .ie_clr(ie_clr), .ie_set(ie_set), .ret(ret),
    .disp_valid(disp_valid), .disp_src(disp_src), .disp_vec(disp_vec),
    .disp_addr(disp_addr), .disp_gp(disp_gp), .ie(ie), .in_service(in_service),
    .fault_addr(fault_addr), .nest_ovf(nest_ovf)
  );

  // reference model state
  longint t_addr [256];
  int     t_ring [256];
  bit     t_pres [256];
  bit     t_trap [256];
  int     q_sie[$], q_intg[$], q_irq[$], q_line[$];
  bit     m_valid, m_gp, m_ie, m_ovf;
  int     m_src, m_vec;
  longint m_addr, m_fa;
  bit [15:0] m_isv;

  int    n_chk = 0, n_fail = 0;
  string cur_tag = "R1";
  bit    done = 0;

  task automatic model_step();
    int  src, v, line;
    bit  old_ie, g, tr;
    bit [15:0] rdy;
    m_valid = 0;
    old_ie  = m_ie;
    src     = 0;
    line    = 0;
    rdy     = irq_lines & ~m_isv;
    for (int i = 15; i >= 0; i--) if (rdy[i]) line = i;
    if (!ret) begin
      if (exc_req)                  src = 1;
      else if (sw_req)              src = 2;
      else if (old_ie && rdy != 0)  src = 3;
    end
    if (ie_clr) m_ie = 0;
    if (ie_set) m_ie = 1;
    if (ret && q_sie.size() > 0) begin
      int s, ig, ir, ln;
      s = q_sie.pop_back(); ig = q_intg.pop_back();
      ir = q_irq.pop_back(); ln = q_line.pop_back();
      if (ir != 0) m_isv[ln] = 0;
      if (ig != 0) m_ie = (s != 0);
    end
    if (src != 0) begin
      if (q_sie.size() >= 8) m_ovf = 1;
      else begin
        v = (src == 1) ? int'(exc_vec) : (src == 2) ? int'(sw_vec) : 32 + line;
        g = !t_pres[v] || (src == 2 && int'(sw_ring) > t_ring[v]);
        if (g) v = 13;
        tr = t_trap[v];
        q_sie.push_back(old_ie); q_intg.push_back(!tr);
        q_irq.push_back(src == 3); q_line.push_back(line);
        if (src == 3) m_isv[line] = 1;
        if (!tr) m_ie = 0;
        if (src == 1 && !g && exc_vec == 5'd14) m_fa = exc_addr;
        m_valid = 1; m_src = src; m_vec = v; m_addr = t_addr[v]; m_gp = g;
      end
    end
    if (cfg_we) begin
      t_addr[cfg_vec] = cfg_addr; t_ring[cfg_vec] = cfg_ring;
      t_pres[cfg_vec] = cfg_present; t_trap[cfg_vec] = cfg_trap;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid = 0; m_ie = 0; m_ovf = 0; m_fa = 0; m_isv = 0;
      m_src = 0; m_vec = 0; m_addr = 0; m_gp = 0;
      q_sie.delete(); q_intg.delete(); q_irq.delete(); q_line.delete();
      for (int i = 0; i < 256; i++) begin
        t_pres[i] = 0; t_addr[i] = 0; t_ring[i] = 0; t_trap[i] = 0;
      end
    end else model_step();
  end

  task automatic chk(string f, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_tag, f, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R11 disp_valid", disp_valid, m_valid);
      if (m_valid) begin
        chk("R11/R8 disp_src", disp_src, m_src);
        chk("R3 disp_vec", disp_vec, m_vec);
        chk("R2 disp_addr", disp_addr, m_addr);
        chk("R4 disp_gp", disp_gp, m_gp);
      end
      chk("R5 ie", ie, m_ie);
      chk("R7 in_service", in_service, m_isv);
      chk("R9 fault_addr", fault_addr, m_fa);
      chk("R10 nest_ovf", nest_ovf, m_ovf);
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(int v, longint a, int r, bit p, bit t);
    cfg_we = 1; cfg_vec = 8'(v); cfg_addr = AW'(a); cfg_ring = 2'(r);
    cfg_present = p; cfg_trap = t;
    cyc(); cfg_we = 0;
  endtask

  task automatic do_ret();
    ret = 1; cyc(); ret = 0; cyc();
  endtask

  task automatic do_sw(int v, int r);
    sw_req = 1; sw_vec = 8'(v); sw_ring = 2'(r);
    for (int k = 0; k < 10; k++) begin
      cyc();
      if (m_valid && m_src == 2) break;
    end
    sw_req = 0; cyc();
  endtask

  task automatic do_exc(int v, longint a);
    exc_req = 1; exc_vec = 5'(v); exc_addr = AW'(a);
    for (int k = 0; k < 10; k++) begin
      cyc();
      if (m_valid && m_src == 1) break;
    end
    exc_req = 0; cyc();
  endtask

  task automatic pulse_ie(bit set);
    if (set) ie_set = 1; else ie_clr = 1;
    cyc(); ie_set = 0; ie_clr = 0; cyc();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cur_tag = "R1";
    cyc(3); rst_n = 1; cyc(3);
    chk("R1 reset ie", ie, 0);
    chk("R1 reset valid", disp_valid, 0);

    cur_tag = "R2";
    cfg(13, 'h1300, 0, 1, 0);
    cfg(14, 'h1400, 0, 1, 1);
    cfg(0, 'h1000, 0, 1, 0);
    cfg(3, 'h1030, 3, 1, 1);
    cfg('h30, 'h3000, 3, 1, 0);
    cfg('h80, 'h8000, 3, 1, 1);
    cfg('h40, 'h4000, 0, 1, 0);
    for (int i = 0; i < 16; i++) cfg(32 + i, 'h2000 + i * 16, 0, (i != 5), 0);
    cyc();

    cur_tag = "R3";
    do_sw('h30, 3); do_ret();
    do_sw('h40, 3); do_ret();
    do_sw('h40, 0); do_ret();

    cur_tag = "R4";
    do_sw('h55, 0); do_ret();
    do_exc(7, 0); do_ret();

    cur_tag = "R12";
    pulse_ie(1); chk("R12 set", ie, 1);
    pulse_ie(0); chk("R12 clr", ie, 0);

    cur_tag = "R5";
    pulse_ie(1);
    do_sw('h30, 3); chk("R5 int gate clears", ie, 0);
    do_ret();       chk("R5 restore", ie, 1);
    do_sw('h80, 3); chk("R5 trap keeps", ie, 1);
    do_ret();
    pulse_ie(0); do_sw('h30, 0); do_ret(); chk("R5 restore clear", ie, 0);

    cur_tag = "R6";
    irq_lines = 16'h0004; cyc(4);
    chk("R6 masked", in_service, 0);
    do_exc(0, 0); do_ret();
    pulse_ie(1); cyc(2);

    cur_tag = "R7";
    chk("R7 line2 held", in_service, 16'h0004);
    cyc(3);
    pulse_ie(1);
    irq_lines = 16'h0006; cyc(3);
    irq_lines = 16'h0000; cyc();
    do_ret(); do_ret(); cyc(2);
    irq_lines = 16'h0020; cyc(2); irq_lines = 0; do_ret();

    cur_tag = "R8";
    pulse_ie(1);
    exc_req = 1; exc_vec = 5'd3; sw_req = 1; sw_vec = 8'h80; sw_ring = 2'd3;
    irq_lines = 16'h0208;
    for (int k = 0; k < 8; k++) begin
      cyc();
      if (m_valid && m_src == 1) exc_req = 0;
      if (m_valid && m_src == 2) sw_req = 0;
    end
    exc_req = 0; sw_req = 0; irq_lines = 0; cyc();
    for (int k = 0; k < 6; k++) do_ret();

    cur_tag = "R9";
    do_exc(14, 'hDEADB000); chk("R9 latched", fault_addr, 'hDEADB000);
    do_ret();
    do_sw(14, 0); do_ret(); chk("R9 software does not latch", fault_addr, 'hDEADB000);

    cur_tag = "R10";
    for (int k = 0; k < 9; k++) do_sw('h80, 3);
    chk("R10 sticky", nest_ovf, 1);
    for (int k = 0; k < 8; k++) do_ret();

    cur_tag = "R13";
    do_ret(); chk("R13 empty return", ie, m_ie);
    ret = 1; sw_req = 1; sw_vec = 8'h30; sw_ring = 2'd3; cyc();
    chk("R13 no dispatch on return", disp_valid, 0);
    ret = 0;
    for (int k = 0; k < 5; k++) begin
      cyc();
      if (m_valid) sw_req = 0;
    end
    sw_req = 0; do_ret(); cyc(3);

    cur_tag = "R11";
    chk("R11 idle", disp_valid, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule